// File: doc/BRIEF.md
# I2C Burst Read Engine with Selectable Final-Byte NACK

This block receives a counted run of data bytes from an I2C target once the address phase is over. One write to its control input starts a burst. The write carries a byte count and a flag that chooses whether the last byte is refused. The engine does not toggle SCL itself. A shared bit engine owns the wires and pulses `bit_strobe` once for each SCL rising edge, with the sampled SDA level on `sda_in`. In the acknowledge slot, this block tells the bit engine whether to pull SDA low.

Each finished byte is pushed into a receive FIFO. Software drains the FIFO one byte per pop. When the acknowledge slot of the last byte completes, a sticky done flag is set. That flag drives the interrupt line when the interrupt is enabled. START, STOP and addressing are handled elsewhere.

Top module: `i2c_burst_rd`

## Requirements
- R1: A control write whose count (bits 6:0) is between 1 and the free FIFO entries starts a burst of that many bytes. Bit 7 of the same write is the NACK-last flag. `clk_req` stays high while the burst runs.
- R2: Each byte takes eight `bit_strobe` pulses, and the first sampled bit is the MSB. The byte is pushed to the FIFO on the eighth pulse, and `sda_pull_low` stays 0 during the eight data slots.
- R3: In the ninth slot of every byte except a NACKed final byte, `sda_pull_low` is 1 (ACK). Outside a burst it is 0.
- R4: In the ninth slot of the final byte, `sda_pull_low` is 0 (NACK) when the NACK-last flag was set and 1 when it was clear.
- R5: At the ninth pulse of the final byte, `rd_done` goes to 1 and `clk_req` goes to 0. `irq` equals `rd_done` AND `irq_en`. `rd_done` is cleared by `done_clr` or by the start of the next burst.
- R6: A control write with a count of zero starts nothing and does not set `rd_done`.
- R7: A control write whose count exceeds the free FIFO entries is ignored. This includes any count above 64.
- R8: A control write during a running burst changes neither the remaining count nor the final-byte answer.
- R9: `pop_data` shows the oldest stored byte, and `pop` removes it. `rx_empty` is 1 exactly when no byte is stored.
- R10: A pop while the FIFO is empty returns zero and leaves the FIFO state unchanged.
- R11: The FIFO holds 64 bytes, so a full 64-byte burst fits. While the FIFO is full, no further burst can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value: count [6:0], NACK-last [7] |
| irq_en | input | 1 | Interrupt enable for the done flag |
| done_clr | input | 1 | Clears the done flag |
| pop | input | 1 | Removes one byte from the FIFO |
| pop_data | output | 8 | Oldest FIFO byte, zero when empty |
| rx_empty | output | 1 | FIFO empty |
| bit_strobe | input | 1 | One pulse per SCL rising edge from the bit engine |
| sda_in | input | 1 | SDA level sampled at that edge |
| clk_req | output | 1 | Burst active; asks the bit engine for slots |
| sda_pull_low | output | 1 | Drive SDA low in the current acknowledge slot |
| rd_done | output | 1 | Sticky burst-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed bytes with distinct top and bottom bits (A5, 3C, 81) show whether bits are shifted in MSB first or reversed. Bursts of one byte, several bytes and the full 64 bytes, each run with the flag set and with it clear, separate a NACK on the last byte from a NACK on every byte or on none. Control writes with a count of zero, with counts above the free space, and during a running burst confirm that no burst starts, no done flag appears, and the final-byte answer does not change. Random burst lengths, random data and partial drains check FIFO ordering under wrap-around, and pops from an empty FIFO show that the pointers stay put.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;
   localparam int CTL_W    = 8;
   localparam int CNT_W    = 7;
   localparam int BYTE_W   = 8;
   localparam int SLOT_W   = 4;
   localparam logic [SLOT_W-1:0] SLOT_ACK = 4'd8;
   localparam logic [SLOT_W-1:0] SLOT_LSB = 4'd7;

   // Field layout of the control write: the flag sits above the count.
   typedef struct packed {
      logic             nack_last;
      logic [CNT_W-1:0] count;
   } ctl_t;
endpackage

// File: rtl/i2cbr_fifo.sv
module i2cbr_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic          empty,
   output logic          full,
   output logic [AW:0]   level
);
   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("i2cbr_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wr_ptr, rd_ptr;
   logic          do_pop;

   assign level  = wr_ptr - rd_ptr;
   assign empty  = (wr_ptr == rd_ptr);
   assign full   = (level == (AW+1)'(DEPTH));
   assign do_pop = pop && !empty;

   generate
      if (DEPTH == 2) begin : g_tiny
         assign pop_data = empty ? '0 : mem[rd_ptr[0]];
      end else begin : g_wide
         assign pop_data = empty ? '0 : mem[rd_ptr[AW-1:0]];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr[AW-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push && !full) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)        rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R11: the launch rule must keep pushes away from a full FIFO
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R10: popping an empty FIFO leaves the read pointer alone
   p_empty_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> $stable(rd_ptr));
endmodule

// File: rtl/i2cbr_seq.sv
module i2cbr_seq
   import i2cbr_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic [AW:0]       free_cnt,
   input  logic              irq_en,
   input  logic              done_clr,
   input  logic              bit_strobe,
   input  logic              sda_in,
   output logic              push,
   output logic [BYTE_W-1:0] push_data,
   output logic              busy,
   output logic              sda_pull_low,
   output logic              rd_done,
   output logic              irq
);
   ctl_t              ctl;
   logic [CNT_W-1:0]  left;
   logic [SLOT_W-1:0] slot;
   logic [BYTE_W-2:0] shreg;
   logic              nack_r;
   logic              launch;
   logic              last_byte;
   logic              finish;

   assign ctl       = ctl_t'(ctl_wdata);
   assign launch    = ctl_we && !busy && (ctl.count != '0)
                      && (32'(ctl.count) <= 32'(free_cnt));
   assign last_byte = (left == CNT_W'(1));
   assign finish    = busy && bit_strobe && (slot == SLOT_ACK) && last_byte;

   assign push         = busy && bit_strobe && (slot == SLOT_LSB);
   assign push_data    = {shreg, sda_in};
   assign sda_pull_low = busy && (slot == SLOT_ACK) && !(nack_r && last_byte);
   assign irq          = rd_done && irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         left    <= '0;
         slot    <= '0;
         shreg   <= '0;
         nack_r  <= 1'b0;
         rd_done <= 1'b0;
      end else begin
         if (done_clr) rd_done <= 1'b0;
         if (launch) begin
            busy    <= 1'b1;
            left    <= ctl.count;
            nack_r  <= ctl.nack_last;
            slot    <= '0;
            rd_done <= 1'b0;
         end else if (busy && bit_strobe) begin
            if (slot == SLOT_ACK) begin
               slot <= '0;
               left <= left - 1'b1;
               if (last_byte) begin
                  busy    <= 1'b0;
                  rd_done <= 1'b1;
               end
            end else begin
               slot  <= slot + 1'b1;
               shreg <= {shreg[BYTE_W-3:0], sda_in};
            end
         end
      end
   end

   // R8: control writes during a burst leave the final-byte answer alone
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_we && !finish) |=> ($stable(nack_r) && busy));
   // R6: a zero count starts nothing
   p_zero_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !busy && ctl.count == '0) |=> !busy);
   // R7: a count beyond the free space starts nothing
   p_over_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !busy && 32'(ctl.count) > 32'(free_cnt)) |=> !busy);
   // R5: done only rises at the end of a running burst
   p_done_from_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_done) |-> ($past(busy) && !busy));
   // R3: no SDA drive outside a burst
   p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_pull_low);
endmodule

// File: rtl/i2c_burst_rd.sv
module i2c_burst_rd
   import i2cbr_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              irq_en,
   input  logic              done_clr,
   input  logic              pop,
   output logic [BYTE_W-1:0] pop_data,
   output logic              rx_empty,
   input  logic              bit_strobe,
   input  logic              sda_in,
   output logic              clk_req,
   output logic              sda_pull_low,
   output logic              rd_done,
   output logic              irq
);
   generate
      if (DEPTH > (1 << CNT_W) - 1) begin : g_bad_depth
         $error("i2c_burst_rd: DEPTH exceeds what the count field can request");
      end
   endgenerate

   logic              push;
   logic [BYTE_W-1:0] push_data;
   logic              full;
   logic [AW:0]       level;
   logic [AW:0]       free_cnt;

   assign free_cnt = (AW+1)'(DEPTH) - level;

   i2cbr_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (pop),
      .pop_data  (pop_data),
      .empty     (rx_empty),
      .full      (full),
      .level     (level)
   );

   i2cbr_seq #(.DEPTH(DEPTH)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_we       (ctl_we),
      .ctl_wdata    (ctl_wdata),
      .free_cnt     (free_cnt),
      .irq_en       (irq_en),
      .done_clr     (done_clr),
      .bit_strobe   (bit_strobe),
      .sda_in       (sda_in),
      .push         (push),
      .push_data    (push_data),
      .busy         (clk_req),
      .sda_pull_low (sda_pull_low),
      .rd_done      (rd_done),
      .irq          (irq)
   );

   // R11: a full FIFO never coexists with an active burst start
   p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clk_req && ctl_we) |=> !clk_req);
endmodule

// File: tb/i2c_burst_rd_tb.sv
`timescale 1ns/1ps
module i2c_burst_rd_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       irq_en = 1'b0;
   logic       done_clr = 1'b0;
   logic       pop = 1'b0;
   logic [7:0] pop_data;
   logic       rx_empty;
   logic       bit_strobe = 1'b0;
   logic       sda_in = 1'b1;
   logic       clk_req, sda_pull_low, rd_done, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [7:0] q[$];

   always #4 clk = ~clk;

   i2c_burst_rd u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .irq_en(irq_en), .done_clr(done_clr), .pop(pop), .pop_data(pop_data),
      .rx_empty(rx_empty), .bit_strobe(bit_strobe), .sda_in(sda_in),
      .clk_req(clk_req), .sda_pull_low(sda_pull_low), .rd_done(rd_done),
      .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit ack_expected(input bit last, input bit nack);
      return !(last && nack);
   endfunction

   task automatic launch(input logic [7:0] v);
      @(negedge clk);
      ctl_wdata = v; ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic slot(input bit b);
      bit_strobe = 1'b1; sda_in = b;
      @(negedge clk);
      bit_strobe = 1'b0; sda_in = 1'b1;
      @(negedge clk);
   endtask

   task automatic rx_byte(input logic [7:0] d, input bit last, input bit nack);
      for (int i = 7; i >= 0; i--) begin
         chk("R2 data slot release", int'(sda_pull_low), 0);
         slot(d[i]);
      end
      if (last) chk("R4 final ack slot", int'(sda_pull_low), int'(ack_expected(1'b1, nack)));
      else      chk("R3 ack slot", int'(sda_pull_low), 1);
      slot(1'b1);
      q.push_back(d);
      if (last) begin
         chk("R5 done set", int'(rd_done), 1);
         chk("R5 clk_req low", int'(clk_req), 0);
      end else begin
         chk("R1 clk_req held", int'(clk_req), 1);
      end
   endtask

   task automatic burst(input int n, input bit nack);
      launch({nack, 7'(n)});
      chk("R1 burst start", int'(clk_req), 1);
      chk("R5 done cleared on launch", int'(rd_done), 0);
      for (int b = 0; b < n; b++) rx_byte(8'($urandom), b == n - 1, nack);
   endtask

   task automatic pop_one();
      chk("R9 empty flag", int'(rx_empty), int'(q.size() == 0));
      chk("R9 pop data", int'(pop_data), (q.size() != 0) ? int'(q[0]) : 0);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      if (q.size() != 0) void'(q.pop_front());
   endtask

   task automatic drain();
      while (q.size() != 0) pop_one();
      chk("R9 empty after drain", int'(rx_empty), 1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset clk_req", int'(clk_req), 0);
      chk("R5 reset done", int'(rd_done), 0);
      chk("R5 reset irq", int'(irq), 0);
      chk("R9 reset empty", int'(rx_empty), 1);
      chk("R3 reset release", int'(sda_pull_low), 0);

      // R10: empty pops return zero and change nothing
      pop_one(); pop_one();
      chk("R10 still empty", int'(rx_empty), 1);

      // R6: zero count
      launch(8'h80);
      chk("R6 zero count no start", int'(clk_req), 0);
      @(negedge clk);
      chk("R6 zero count no done", int'(rd_done), 0);

      // R7: counts beyond free space
      launch(8'h41);
      chk("R7 count 65 ignored", int'(clk_req), 0);
      launch(8'h7f);
      chk("R7 count 127 ignored", int'(clk_req), 0);

      // R2 / R4: directed bytes, final NACK
      launch(8'h83);
      chk("R1 start of 3", int'(clk_req), 1);
      rx_byte(8'hA5, 1'b0, 1'b1);
      rx_byte(8'h3C, 1'b0, 1'b1);
      rx_byte(8'h81, 1'b1, 1'b1);
      chk("R10 byte after empty pops", int'(pop_data), 8'hA5);
      drain();

      // R5: irq gating and clearing
      irq_en = 1'b1;
      @(negedge clk);
      chk("R5 irq enabled", int'(irq), 1);
      irq_en = 1'b0;
      @(negedge clk);
      chk("R5 irq masked", int'(irq), 0);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R5 done cleared", int'(rd_done), 0);

      // R8: write during a burst is ignored (flag clear, count 2)
      launch(8'h02);
      rx_byte(8'h5A, 1'b0, 1'b0);
      launch(8'h85);
      chk("R8 still running", int'(clk_req), 1);
      rx_byte(8'hC3, 1'b1, 1'b0);
      chk("R8 stops at original count", int'(clk_req), 0);
      drain();

      // Random bursts with partial drains
      for (int it = 0; it < 24; it++) begin
         int n = 1 + ($urandom % 8);
         bit nk = 1'($urandom);
         if (n > 64 - q.size()) drain();
         burst(n, nk);
         repeat ($urandom % (q.size() + 1)) pop_one();
      end
      drain();

      // R11: full 64-byte burst, then a blocked launch
      burst(64, 1'b1);
      chk("R11 holds 64", int'(rx_empty), 0);
      launch(8'h01);
      chk("R11 full blocks launch", int'(clk_req), 0);
      drain();
      pop_one();
      chk("R10 empty after full drain", int'(rx_empty), 1);

      summary();
   end
endmodule